// File: doc/BRIEF.md
# Timer Channel Event Flag Register

This block keeps one sticky event bit for each channel of a multi-channel timer. It collects event strobes from the rest of the timer and latches them into an eight-bit status word. The strobes are capture or compare detections, plus pulses from the pulse accumulators on the low channels. Software reads the word at any time. It clears bits either by writing ones over a plain register bus, or, in a fast-clear mode, as a side effect of touching a channel's data register. A per-channel enable mask gates the flags into one registered interrupt request.

Capture and compare events can be shaped before they reach the flag. A per-channel delay can hold the flag back for a programmed number of cycles. A paired-capture mode, active on channels that have overwrite protection, raises the flag only on every second capture. This way the interrupt comes once both the capture latch and the holding latch are full.

Top module: `tmr_evt_flags`

## Requirements
- R1: While reset is applied, `rd_data` and `irq` are zero.
- R2: A `cap_evt[i]` pulse on a channel with no delay and no pairing sets `rd_data[i]` at the clock edge that samples it. Bit i of `rd_data` belongs to channel i, with channel 0 in bit 0.
- R3: With `fast_clr` low, a bus write (`wr_en` high) clears every flag whose `wr_data` bit is one and leaves flags with a zero data bit unchanged.
- R4: With `fast_clr` high, a bus write of ones clears nothing.
- R5: With `fast_clr` high, `acc_stb[i]` clears flag i at the sampling edge. With `fast_clr` low, `acc_stb` has no effect.
- R6: A `pa16_evt` pulse sets flag 0.
- R7: A `pa8_evt[j]` pulse sets flag j, for channels 0 to 3.
- R8: With `dly_en[i]` high and `dly_cycles` = D, a capture event sets flag i D edges after the edge that samples the event. D = 0 gives no delay. Lowering `dly_en[i]` cancels a pending delay.
- R9: A capture event on a channel whose delay is already running is dropped.
- R10: With `pair_mode` high and `ovw_prot[i]` high, only every second capture event on channel i sets its flag. Lowering either input restarts the pairing.
- R11: When a set and a clear reach the same flag in the same cycle, the flag ends up set. This holds for both bus clears and fast clears.
- R12: `irq` is one exactly one edge after some `rd_data[i] & irq_en[i]` is one, and zero one edge after no such bit is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_evt | input | 8 | Capture or compare event strobes, one per channel |
| pa16_evt | input | 1 | Wide pulse accumulator strobe, sets channel 0 |
| pa8_evt | input | 4 | Narrow pulse accumulator strobes for channels 0 to 3 |
| dly_en | input | 8 | Per-channel enable of the event delay |
| dly_cycles | input | 8 | Delay length in cycles |
| pair_mode | input | 1 | Paired-capture mode |
| ovw_prot | input | 8 | Per-channel overwrite protection; together with pair_mode it selects pairing |
| wr_en | input | 1 | Bus write strobe for the flag register |
| wr_data | input | 8 | Bus write data; ones clear flags |
| fast_clr | input | 1 | Fast-clear mode select |
| acc_stb | input | 8 | Per-channel data register access strobe |
| irq_en | input | 8 | Per-channel interrupt enables |
| rd_data | output | 8 | Current flag bits |
| irq | output | 1 | Registered interrupt request |

## Verification
A direct set or clear reaches `rd_data` at the edge that samples the strobe. A delayed set arrives D edges later, and `irq` follows the flags by one more edge. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each such read falls exactly one rising edge after the stimulus. For delay tests it reads the flag after every edge through D+2 edges, so both the edge before the set and the edge of the set are checked.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  // per-channel request toward the flag register
  typedef struct packed {
    logic set;
    logic clr;
  } chan_req_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             cap_evt,
  input  logic             pair_on,
  input  logic             dly_on,
  input  logic [DLY_W-1:0] dly_cycles,
  output logic             set_out
);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;
  localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             half_q, half_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             qual;

  // pairing stage: first capture only arms, second one passes
  always_comb begin
    half_d = half_q;
    qual   = cap_evt;
    if (!pair_on) begin
      half_d = 1'b0;
    end else if (cap_evt) begin
      half_d = ~half_q;
      qual   = half_q;
    end
  end

  // delay stage
  always_comb begin
    cnt_d   = cnt_q;
    set_out = 1'b0;
    if (!dly_on) begin
      cnt_d   = CNT_ZERO;
      set_out = qual;
    end else if (cnt_q != CNT_ZERO) begin
      cnt_d   = cnt_q - CNT_ONE;
      set_out = (cnt_q == CNT_ONE);
    end else if (qual) begin
      if (dly_cycles == CNT_ZERO) set_out = 1'b1;
      else                        cnt_d   = dly_cycles;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      half_q <= 1'b0;
      cnt_q  <= CNT_ZERO;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] flags_d;
  logic           upd;

  // set has priority over clear
  always_comb begin
    flags_d = (flags & ~clr_vec) | set_vec;
    upd     = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)   flags <= '0;
    else if (upd) flags <= flags_d;
  end
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] irq_en,
  output logic           irq
);
  logic irq_d;

  always_comb irq_d = |(flags & irq_en);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned PA8_CH  = 4,
  parameter int unsigned PA16_CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_evt,
  input  logic              pa16_evt,
  input  logic [PA8_CH-1:0] pa8_evt,
  input  logic [NCH-1:0]    dly_en,
  input  logic [DLY_W-1:0]  dly_cycles,
  input  logic              pair_mode,
  input  logic [NCH-1:0]    ovw_prot,
  input  logic              wr_en,
  input  logic [NCH-1:0]    wr_data,
  input  logic              fast_clr,
  input  logic [NCH-1:0]    acc_stb,
  input  logic [NCH-1:0]    irq_en,
  output logic [NCH-1:0]    rd_data,
  output logic              irq
);
  import tmr_evt_pkg::*;

  logic           rst_q;
  logic [NCH-1:0] cap_set;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] flags;
  chan_req_t      req [NCH];

  tmr_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic aux_set;

    tmr_evt_chan #(.DLY_W(DLY_W)) u_chan (
      .clk        (clk),
      .rst_q      (rst_q),
      .cap_evt    (cap_evt[i]),
      .pair_on    (pair_mode & ovw_prot[i]),
      .dly_on     (dly_en[i]),
      .dly_cycles (dly_cycles),
      .set_out    (cap_set[i])
    );

    if (i < PA8_CH && i == PA16_CH) begin : g_both
      assign aux_set = pa8_evt[i] | pa16_evt;
    end else if (i < PA8_CH) begin : g_pa8
      assign aux_set = pa8_evt[i];
    end else if (i == PA16_CH) begin : g_pa16
      assign aux_set = pa16_evt;
    end else begin : g_none
      assign aux_set = 1'b0;
    end

    always_comb begin
      req[i].set = cap_set[i] | aux_set;
      req[i].clr = fast_clr ? acc_stb[i] : (wr_en & wr_data[i]);
      set_vec[i] = req[i].set;
      clr_vec[i] = req[i].clr;
    end
  end

  tmr_flag_bank #(.NCH(NCH)) u_bank (
    .clk     (clk),
    .rst_q   (rst_q),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  tmr_irq_gen #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_q  (rst_q),
    .flags  (flags),
    .irq_en (irq_en),
    .irq    (irq)
  );

  assign rd_data = flags;
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned PA8_CH  = 4,
  parameter int unsigned PA16_CH = 0
) (
  input logic              clk,
  input logic              rst_q,
  input logic [NCH-1:0]    cap_evt,
  input logic              pa16_evt,
  input logic [PA8_CH-1:0] pa8_evt,
  input logic [NCH-1:0]    dly_en,
  input logic              pair_mode,
  input logic [NCH-1:0]    ovw_prot,
  input logic              wr_en,
  input logic [NCH-1:0]    wr_data,
  input logic              fast_clr,
  input logic [NCH-1:0]    acc_stb,
  input logic [NCH-1:0]    irq_en,
  input logic [NCH-1:0]    rd_data,
  input logic              irq
);
  always @(posedge clk) begin
    if (!rst_q) begin
      a_r1_reset_clear: assert (rd_data == '0 && irq == 1'b0)
        else $error("R1 outputs not clear in reset");
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_a
    logic aux;
    if (i < PA8_CH && i == PA16_CH) begin : g_both
      assign aux = pa8_evt[i] | pa16_evt;
    end else if (i < PA8_CH) begin : g_pa8
      assign aux = pa8_evt[i];
    end else if (i == PA16_CH) begin : g_pa16
      assign aux = pa16_evt;
    end else begin : g_none
      assign aux = 1'b0;
    end

    a_r2_direct_set: assert property (@(posedge clk) disable iff (!rst_q)
      cap_evt[i] && !dly_en[i] && !(pair_mode && ovw_prot[i]) |=> rd_data[i]);

    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_q)
      !fast_clr && wr_en && wr_data[i] && !cap_evt[i] && !dly_en[i] && !aux
      |=> !rd_data[i]);

    a_r4_fast_keeps: assert property (@(posedge clk) disable iff (!rst_q)
      fast_clr && rd_data[i] && !acc_stb[i] |=> rd_data[i]);

    a_r5_fast_access_clear: assert property (@(posedge clk) disable iff (!rst_q)
      fast_clr && acc_stb[i] && !cap_evt[i] && !dly_en[i] && !aux
      |=> !rd_data[i]);

    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_q)
      !rd_data[i] && !cap_evt[i] && !dly_en[i] && !aux |=> !rd_data[i]);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_q)
      aux && (acc_stb[i] || wr_data[i]) |=> rd_data[i]);
  end

  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_q)
    |(rd_data & irq_en) |=> irq);

  a_r12_irq_fall: assert property (@(posedge clk) disable iff (!rst_q)
    !(|(rd_data & irq_en)) |=> !irq);
endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(
  .NCH(NCH), .PA8_CH(PA8_CH), .PA16_CH(PA16_CH)
) u_chk (
  .clk(clk), .rst_q(rst_q), .cap_evt(cap_evt), .pa16_evt(pa16_evt),
  .pa8_evt(pa8_evt), .dly_en(dly_en), .pair_mode(pair_mode),
  .ovw_prot(ovw_prot), .wr_en(wr_en), .wr_data(wr_data),
  .fast_clr(fast_clr), .acc_stb(acc_stb), .irq_en(irq_en),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_tmr_evt_flags.sv
module tb_tmr_evt_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cap_evt, dly_en, ovw_prot, wr_data, acc_stb, irq_en, dly_cycles;
  logic [3:0] pa8_evt;
  logic       pa16_evt, pair_mode, wr_en, fast_clr;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0;
  int n_err = 0;

  tmr_evt_flags dut (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .pa16_evt(pa16_evt),
    .pa8_evt(pa8_evt), .dly_en(dly_en), .dly_cycles(dly_cycles),
    .pair_mode(pair_mode), .ovw_prot(ovw_prot), .wr_en(wr_en),
    .wr_data(wr_data), .fast_clr(fast_clr), .acc_stb(acc_stb),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wipe();
    fast_clr = 1'b0; wr_en = 1'b1; wr_data = 8'hFF;
    tick();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_evt = '0; pa16_evt = 0; pa8_evt = '0; dly_en = '0;
    dly_cycles = '0; pair_mode = 0; ovw_prot = '0; wr_en = 0; wr_data = '0;
    fast_clr = 0; acc_stb = '0; irq_en = '0;
    tick(); tick();
    chk("R1 flags in reset", rd_data, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 flags after release", rd_data, 8'h00);

    // R2: sweep channels, flags accumulate
    for (int ch = 0; ch < 8; ch++) begin
      cap_evt = 8'(1 << ch); tick(); cap_evt = '0;
      chk("R2 capture sets own bit", rd_data, 8'((1 << (ch + 1)) - 1));
    end

    // R3: write one to clear, zeros keep
    wr_en = 1; wr_data = 8'hA5; tick(); wr_en = 0;
    chk("R3 partial clear", rd_data, 8'h5A);
    wr_en = 1; wr_data = 8'h5A; tick(); wr_en = 0;
    chk("R3 remaining clear", rd_data, 8'h00);

    // R4 / R5: fast clear
    cap_evt = 8'hFF; tick(); cap_evt = '0;
    fast_clr = 1; wr_en = 1; wr_data = 8'hFF; tick(); wr_en = 0;
    chk("R4 write ignored in fast mode", rd_data, 8'hFF);
    for (int ch = 0; ch < 8; ch++) begin
      acc_stb = 8'(1 << ch); tick(); acc_stb = '0;
      chk("R5 access clears one flag", rd_data, 8'hFF << (ch + 1));
    end
    fast_clr = 0; cap_evt = 8'hFF; tick(); cap_evt = '0;
    acc_stb = 8'hFF; tick(); acc_stb = '0;
    chk("R5 access ignored outside fast mode", rd_data, 8'hFF);
    wipe();

    // R6 / R7: pulse accumulators
    pa16_evt = 1; tick(); pa16_evt = 0;
    chk("R6 wide accumulator sets ch0", rd_data, 8'h01);
    wipe();
    for (int j = 0; j < 4; j++) begin
      pa8_evt = 4'(1 << j); tick(); pa8_evt = '0;
      chk("R7 narrow accumulator sets own ch", rd_data, 8'(1 << j));
      wipe();
    end

    // R8: delay sweep on channel 2
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 5;
      dly_en = 8'h04; dly_cycles = 8'(d);
      cap_evt = 8'h04; tick(); cap_evt = '0;
      for (int k = 1; k <= d + 2; k++) begin
        if (k > 1) tick();
        chk("R8 delayed set timing", rd_data & 8'h04, (k > d) ? 8'h04 : 8'h00);
      end
      dly_en = '0; wipe();
    end

    // R9: second event during running delay is dropped
    dly_en = 8'h04; dly_cycles = 8'd4;
    cap_evt = 8'h04; tick(); cap_evt = '0; tick();
    cap_evt = 8'h04; tick(); cap_evt = '0; tick(); tick();
    chk("R9 first delayed set", rd_data, 8'h04);
    wr_en = 1; wr_data = 8'h04; tick(); wr_en = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R9 dropped event never sets", rd_data, 8'h00);
    end
    dly_en = '0; wipe();

    // R10: paired capture on ch5, ch6 unpaired
    pair_mode = 1; ovw_prot = 8'h20;
    cap_evt = 8'h60; tick(); cap_evt = '0;
    chk("R10 first capture only arms", rd_data, 8'h40);
    cap_evt = 8'h20; tick(); cap_evt = '0;
    chk("R10 second capture sets", rd_data, 8'h60);
    wipe();
    cap_evt = 8'h20; tick(); cap_evt = '0;
    chk("R10 pairing restarts", rd_data, 8'h00);
    pair_mode = 0; tick();
    pair_mode = 1; cap_evt = 8'h20; tick(); cap_evt = '0;
    chk("R10 mode drop resets pairing", rd_data, 8'h00);
    pair_mode = 0; ovw_prot = '0; wipe();

    // R11: set beats clear
    cap_evt = 8'h02; wr_en = 1; wr_data = 8'h02; tick();
    cap_evt = '0; wr_en = 0;
    chk("R11 set wins over bus clear", rd_data, 8'h02);
    fast_clr = 1; cap_evt = 8'h08; acc_stb = 8'h0A; tick();
    cap_evt = '0; acc_stb = '0; fast_clr = 0;
    chk("R11 set wins over fast clear", rd_data, 8'h08);
    wipe(); tick();

    // R12: interrupt timing per channel
    for (int ch = 0; ch < 8; ch++) begin
      irq_en = 8'(1 << ch);
      cap_evt = 8'(1 << ch); tick(); cap_evt = '0;
      chk("R12 irq not yet", {7'd0, irq}, 8'h00);
      tick();
      chk("R12 irq one edge after flag", {7'd0, irq}, 8'h01);
      irq_en = ~8'(1 << ch); tick();
      chk("R12 irq drops when masked", {7'd0, irq}, 8'h00);
      irq_en = '0; wipe(); tick();
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule